// File: doc/BRIEF.md
# Self-Calibrating SAR Conversion Sequencer

This block is the digital controller of a successive-approximation converter. Its result is a sign bit plus a 12-bit magnitude, and it is delivered as a 13-bit two's-complement word. A host reaches it through a bus-style port with active-low chip select, write, read and calibrate strobes. It reports a finished result on an active-low interrupt line. On the analog side it drives a trial code for the internal DAC, a track/hold control, an auto-zero control and a calibration strobe. It reads back one comparator bit.

The host pulls CAL low to start a calibration phase of fixed length. A write strobe with chip select starts a conversion when the strobe is released. Each conversion is an acquisition window, then a search that resolves the sign first and then the magnitude from MSB to LSB, then idle padding. When the mode input is set, an auto-zero phase runs before the acquisition. Every strobe passes through a two-flop synchronizer before it reaches the sequencer. The data bus is modelled as a value plus an output-enable, and that enable follows RD and CS directly.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The search holds the trial bit when `comp_in` is 1 and clears it when `comp_in` is 0. It tries `dac_code` bit 12 (sign) first, then bits 11 down to 0, one bit per clock. The latched result equals the magnitude when the sign bit is 0, and the 13-bit two's-complement negation of the magnitude when the sign bit is 1, so a negative zero gives 0.
- R2: With `az_en` low, `busy` stays high for exactly 27 cycles per conversion. The first 7 of them have `sh_track` high.
- R3: With `az_en` high, `az_active` is high for 26 cycles and is followed at once by the 27-cycle conversion, so `busy` lasts 53 cycles.
- R4: A falling edge on `cal_n` starts a calibration with `cal_phase` and `busy` high for 1396 cycles. Releasing `cal_n` starts nothing.
- R5: A write released while `cal_n` is still low does not start a conversion.
- R6: A write or a calibration request that arrives while `busy` is high is ignored. The running conversion keeps its length and its result.
- R7: `int_n` goes low in the same cycle that `busy` drops at the end of a conversion. It stays low until a falling edge of RD or WR (with `cs_n` low) sets it high again, within 4 cycles.
- R8: `dout_oe` is high only while both `rd_n` and `cs_n` are low. `dout` carries the latched result then, and is zero otherwise.
- R9: After reset, `int_n` is 1, `busy` is 0, `dout_oe` is 0 and `dac_code` is 0.
- R10: A write pulse with `cs_n` high does not start a conversion.
- R11: `dac_code` is zero during acquisition and auto-zero, and at most one of `sh_track`, `az_active` and `cal_phase` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; its release starts a conversion |
| rd_n | input | 1 | Read strobe, active low |
| cal_n | input | 1 | Calibration request, active low; its falling edge starts calibration |
| az_en | input | 1 | Inserts auto-zero before each conversion when high |
| comp_in | input | 1 | Comparator decision for the current trial code |
| int_n | output | 1 | Result-ready flag, active low |
| dout | output | 13 | Two's-complement result, zero when not enabled |
| dout_oe | output | 1 | Output enable for the data bus |
| dac_code | output | 13 | Trial code to the DAC (sign-magnitude) |
| sh_track | output | 1 | Sample/hold tracks while high |
| az_active | output | 1 | Auto-zero phase in progress |
| cal_phase | output | 1 | Calibration phase in progress |
| busy | output | 1 | Sequencer is not idle |

## Verification
The comparator is modelled from the trial code, so the bench covers full-scale positive, full-scale negative, negative zero and minus one. A design that negated the magnitude wrongly, or searched in the wrong bit order, would return a different word. The bench holds CAL low through and past a calibration and then writes. A sequencer that ignored the CAL level would start a conversion there, and one that acted on the CAL rising edge would calibrate a second time. The bench also fires WR and CAL in the middle of a conversion. A design that re-armed would show a stretched `busy`, a second conversion or a calibration phase. The interrupt is checked against both release paths and against a quiet stretch, which exposes a flag that clears itself or misses an edge.

// File: rtl/sar_seq_pkg.sv
// Package: shared phase encoding for the SAR sequencer.
// Assumes: one phase active at a time; IDLE is the reset phase.
package sar_seq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CAL  = 3'd1,
        PH_AZ   = 3'd2,
        PH_ACQ  = 3'd3,
        PH_SAR  = 3'd4
    } phase_t;
endpackage

// File: rtl/sar_edge_sync.sv
// Two-flop synchronizer with a third stage for edge detection, W lanes wide.
// Assumes: inputs are asynchronous levels; all outputs are in the clk domain
// and edges are single-cycle pulses three clocks after the input changes.
module sar_edge_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, stab_q, prev_q;

    // Purpose: resynchronize the strobes and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    // Purpose: derive level and edge pulses from the stable stages.
    always_comb begin
        level = stab_q;
        rise  = stab_q & ~prev_q;
        fall  = ~stab_q & prev_q;
    end
endmodule

// File: rtl/sar_phase_fsm.sv
// Phase sequencer: IDLE -> CAL, or IDLE -> [AZ] -> ACQ -> SAR -> IDLE.
// Assumes: start requests are one-cycle pulses and are honoured only in IDLE;
// calibration wins when both arrive in the same cycle. SAR covers the
// search steps plus padding so that ACQ + SAR equals CONV_CYCLES.
module sar_phase_fsm
    import sar_seq_pkg::*;
#(
    parameter int CAL_CYCLES  = 1396,
    parameter int ACQ_CYCLES  = 7,
    parameter int AZ_CYCLES   = 26,
    parameter int CONV_CYCLES = 27,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cal,
    input  logic             start_conv,
    input  logic             az_en,
    output phase_t           phase,
    output logic [CNT_W-1:0] step_cnt,
    output logic             conv_done
);
    localparam int SAR_CYCLES = CONV_CYCLES - ACQ_CYCLES;
    localparam logic [CNT_W-1:0] CAL_LAST = CNT_W'(CAL_CYCLES - 1);
    localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYCLES - 1);
    localparam logic [CNT_W-1:0] AZ_LAST  = CNT_W'(AZ_CYCLES - 1);
    localparam logic [CNT_W-1:0] SAR_LAST = CNT_W'(SAR_CYCLES - 1);

    phase_t           phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: advance the phase and its cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start_cal)       phase_q <= PH_CAL;
                    else if (start_conv) phase_q <= az_en ? PH_AZ : PH_ACQ;
                end
                PH_CAL: begin
                    if (cnt_q == CAL_LAST) begin phase_q <= PH_IDLE; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
                end
                PH_AZ: begin
                    if (cnt_q == AZ_LAST) begin phase_q <= PH_ACQ; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
                end
                PH_ACQ: begin
                    if (cnt_q == ACQ_LAST) begin phase_q <= PH_SAR; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
                end
                PH_SAR: begin
                    if (cnt_q == SAR_LAST) begin phase_q <= PH_IDLE; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Purpose: expose the state and flag the final conversion cycle.
    always_comb begin
        phase     = phase_q;
        step_cnt  = cnt_q;
        conv_done = (phase_q == PH_SAR) && (cnt_q == SAR_LAST);
    end
endmodule

// File: rtl/sar_search_reg.sv
// Successive-approximation register: one bit decided per enabled step,
// MSB first (step 0 -> bit NBITS-1). Trial bit is shown through `trial`.
// Assumes: `clear` is held whenever no search is running.
module sar_search_reg #(
    parameter int NBITS = 13,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step_en,
    input  logic [CNT_W-1:0] step,
    input  logic             comp_in,
    output logic [NBITS-1:0] code_q,
    output logic [NBITS-1:0] trial
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        localparam logic [CNT_W-1:0] MY_STEP = CNT_W'(NBITS - 1 - i);
        logic bit_q;
        logic hit;

        assign hit = step_en && (step == MY_STEP);

        // Purpose: clear, or keep the trial bit per the comparator.
        always_ff @(posedge clk) begin
            if (!rst_n)      bit_q <= 1'b0;
            else if (clear)  bit_q <= 1'b0;
            else if (hit)    bit_q <= comp_in;
        end

        assign code_q[i] = bit_q;
        assign trial[i]  = hit;
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
// Top: SAR conversion sequencer with calibration, optional auto-zero,
// interrupt handshake and gated result bus.
// Assumes: host strobes are asynchronous; the bus tri-state is modelled by
// dout_oe with dout forced to zero while disabled.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS       = 13,
    parameter int CAL_CYCLES  = 1396,
    parameter int ACQ_CYCLES  = 7,
    parameter int AZ_CYCLES   = 26,
    parameter int CONV_CYCLES = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cal_n,
    input  logic             az_en,
    input  logic             comp_in,
    output logic             int_n,
    output logic [NBITS-1:0] dout,
    output logic             dout_oe,
    output logic [NBITS-1:0] dac_code,
    output logic             sh_track,
    output logic             az_active,
    output logic             cal_phase,
    output logic             busy
);
    localparam int CNT_W = $clog2(CAL_CYCLES + 1);
    localparam int L_WR  = 0;
    localparam int L_RD  = 1;
    localparam int L_CAL = 2;
    localparam logic [CNT_W-1:0] NSTEPS = CNT_W'(NBITS);

    logic [2:0]       strobe_raw, s_lvl, s_rise, s_fall;
    phase_t           phase;
    logic [CNT_W-1:0] step_cnt;
    logic             conv_done, start_cal, start_conv, step_en;
    logic [NBITS-1:0] code_q, trial, mag_ext, signed_word, result_q;

    assign strobe_raw = {~cal_n, ~rd_n & ~cs_n, ~wr_n & ~cs_n};

    sar_edge_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(strobe_raw),
        .level(s_lvl), .rise(s_rise), .fall(s_fall)
    );

    assign start_cal  = s_rise[L_CAL];
    assign start_conv = s_fall[L_WR] & ~s_lvl[L_CAL];

    sar_phase_fsm #(
        .CAL_CYCLES(CAL_CYCLES), .ACQ_CYCLES(ACQ_CYCLES),
        .AZ_CYCLES(AZ_CYCLES), .CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_cal(start_cal), .start_conv(start_conv),
        .az_en(az_en), .phase(phase), .step_cnt(step_cnt), .conv_done(conv_done)
    );

    assign step_en = (phase == PH_SAR) && (step_cnt < NSTEPS);

    sar_search_reg #(.NBITS(NBITS), .CNT_W(CNT_W)) u_sreg (
        .clk(clk), .rst_n(rst_n), .clear(phase != PH_SAR), .step_en(step_en),
        .step(step_cnt), .comp_in(comp_in), .code_q(code_q), .trial(trial)
    );

    // Purpose: turn the sign-magnitude search word into two's complement.
    always_comb begin
        mag_ext     = {1'b0, code_q[NBITS-2:0]};
        signed_word = code_q[NBITS-1] ? (~mag_ext + NBITS'(1)) : mag_ext;
    end

    // Purpose: latch the result and drive the interrupt handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            int_n    <= 1'b1;
        end else if (conv_done) begin
            result_q <= signed_word;
            int_n    <= 1'b0;
        end else if (s_rise[L_RD] || s_rise[L_WR]) begin
            int_n    <= 1'b1;
        end
    end

    // Purpose: decode phase controls and gate the data bus.
    always_comb begin
        dac_code  = code_q | trial;
        sh_track  = (phase == PH_ACQ);
        az_active = (phase == PH_AZ);
        cal_phase = (phase == PH_CAL);
        busy      = (phase != PH_IDLE);
        dout_oe   = ~rd_n & ~cs_n;
        dout      = dout_oe ? result_q : '0;
    end
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
// Checker for sar_seq_ctrl: phase lengths via run counters, phase exclusivity,
// interrupt timing and bus gating. Attached to every instance by bind.
module sar_seq_ctrl_chk #(
    parameter int NBITS      = 13,
    parameter int CAL_CYCLES = 1396,
    parameter int ACQ_CYCLES = 7,
    parameter int AZ_CYCLES  = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_n,
    input logic [NBITS-1:0] dout,
    input logic             dout_oe,
    input logic [NBITS-1:0] dac_code,
    input logic             sh_track,
    input logic             az_active,
    input logic             cal_phase,
    input logic             busy
);
    logic [15:0] acq_run, az_run, cal_run;

    // Purpose: count consecutive cycles of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_run <= '0;
            az_run  <= '0;
            cal_run <= '0;
        end else begin
            acq_run <= sh_track  ? acq_run + 16'd1 : 16'd0;
            az_run  <= az_active ? az_run  + 16'd1 : 16'd0;
            cal_run <= cal_phase ? cal_run + 16'd1 : 16'd0;
        end
    end

    assert_acq_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_track) |-> acq_run == 16'(ACQ_CYCLES));
    assert_az_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(az_active) |-> az_run == 16'(AZ_CYCLES));
    assert_az_into_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(az_active) |-> sh_track);
    assert_cal_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_phase) |-> cal_run == 16'(CAL_CYCLES));
    assert_cal_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_phase) |-> !$past(busy));
    assert_int_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> $fell(busy));
    assert_bus_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == '0);
    assert_dac_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_track || az_active) |-> dac_code == '0);
    assert_phase_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sh_track, az_active, cal_phase}));
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
    .NBITS(NBITS), .CAL_CYCLES(CAL_CYCLES),
    .ACQ_CYCLES(ACQ_CYCLES), .AZ_CYCLES(AZ_CYCLES)
) u_chk (.*);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cal_n = 1'b1, az_en = 1'b0;
    logic comp_in;
    logic int_n, dout_oe, sh_track, az_active, cal_phase, busy;
    logic [12:0] dout, dac_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit tgt_s = 0;
    int tgt_m = 0;

    always #2 clk = ~clk;

    // Comparator model: sign step has zero magnitude bits, else compare magnitude.
    assign comp_in = (dac_code[11:0] == 12'd0) ? tgt_s : (int'(dac_code[11:0]) <= tgt_m);

    sar_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cal_n(cal_n), .az_en(az_en), .comp_in(comp_in), .int_n(int_n),
        .dout(dout), .dout_oe(dout_oe), .dac_code(dac_code),
        .sh_track(sh_track), .az_active(az_active), .cal_phase(cal_phase), .busy(busy)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_wr(bit with_cs);
        cs_n = !with_cs; wr_n = 1'b0;
        tick(3);
        wr_n = 1'b1;
        tick(1);
        cs_n = 1'b1;
    endtask

    task automatic wait_busy(output bit seen);
        seen = 0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (busy) seen = 1; else tick(1);
        end
    endtask

    function automatic int expect_word(bit s, int m);
        return s ? ((8192 - m) % 8192) : m;
    endfunction

    task automatic read_check(string req, int exp);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk({req, " oe during read (R8)"}, dout_oe, 1);
        chk({req, " result word"}, dout, exp);
        tick(4);
        chk("R7 int released by RD", int_n, 1);
        rd_n = 1'b1; cs_n = 1'b1;
        #1;
        chk("R8 bus off after read", dout_oe, 0);
        chk("R8 dout zero when off", dout, 0);
    endtask

    // One full conversion, counting busy, acquisition and auto-zero cycles.
    task automatic run_conv(bit s, int m, bit az, bit do_read);
        bit seen;
        int nb = 0, nacq = 0, naz = 0;
        tgt_s = s; tgt_m = m; az_en = az;
        pulse_wr(1);
        wait_busy(seen);
        chk("R2 conversion started", seen, 1);
        while (busy && nb < 200) begin
            nb++; nacq += sh_track; naz += az_active;
            tick(1);
        end
        chk(az ? "R3 busy length with auto-zero" : "R2 busy length", nb, az ? 53 : 27);
        chk("R2 acquisition cycles", nacq, 7);
        chk("R3 auto-zero cycles", naz, az ? 26 : 0);
        chk("R7 int low as busy drops", int_n, 0);
        if (do_read) read_check("R1", expect_word(s, m));
    endtask

    task automatic test_reset();
        chk("R9 reset int_n", int_n, 1);
        chk("R9 reset busy", busy, 0);
        chk("R9 reset dout_oe", dout_oe, 0);
        chk("R9 reset dac_code", dac_code, 0);
    endtask

    task automatic test_values();
        run_conv(0, 1234, 0, 1);
        run_conv(0, 4095, 0, 1);
        run_conv(1, 4095, 0, 1);
        run_conv(1, 0, 0, 1);
        run_conv(1, 1, 0, 1);
        run_conv(0, 0, 0, 1);
        run_conv(1, 2730, 1, 1);
    endtask

    task automatic test_cal_hold();
        bit seen;
        int nb = 0, ncal = 0, stray = 0;
        cal_n = 1'b0;
        wait_busy(seen);
        chk("R4 calibration started", seen, 1);
        while (busy && nb < 3000) begin
            nb++; ncal += cal_phase;
            tick(1);
        end
        chk("R4 calibration busy length", nb, 1396);
        chk("R4 cal_phase length", ncal, 1396);
        tgt_s = 0; tgt_m = 77;
        pulse_wr(1);
        for (int i = 0; i < 40; i++) begin stray += busy; tick(1); end
        chk("R5 write under CAL low ignored", stray, 0);
        cal_n = 1'b1;
        stray = 0;
        for (int i = 0; i < 20; i++) begin stray += busy; tick(1); end
        chk("R4 CAL release starts nothing", stray, 0);
    endtask

    task automatic test_busy_ignore();
        bit seen;
        int nb = 0, stray = 0, cals = 0;
        tgt_s = 0; tgt_m = 300; az_en = 0;
        pulse_wr(1);
        wait_busy(seen);
        while (busy && nb < 200) begin
            if (nb == 5)  begin cs_n = 1'b0; wr_n = 1'b0; end
            if (nb == 8)  begin wr_n = 1'b1; cs_n = 1'b1; end
            if (nb == 10) cal_n = 1'b0;
            if (nb == 12) cal_n = 1'b1;
            cals += cal_phase;
            nb++;
            tick(1);
        end
        chk("R6 busy length under extra requests", nb, 27);
        for (int i = 0; i < 40; i++) begin stray += busy; cals += cal_phase; tick(1); end
        chk("R6 no restart after busy", stray, 0);
        chk("R6 no calibration from busy request", cals, 0);
        read_check("R6", 300);
    endtask

    task automatic test_cs_gate();
        int stray = 0;
        pulse_wr(0);
        for (int i = 0; i < 40; i++) begin stray += busy; tick(1); end
        chk("R10 write without CS ignored", stray, 0);
        cs_n = 1'b1; rd_n = 1'b0;
        #1;
        chk("R8 read without CS keeps bus off", dout_oe, 0);
        rd_n = 1'b1;
    endtask

    task automatic test_int_by_wr();
        run_conv(1, 5, 0, 0);
        tick(10);
        chk("R7 int holds low while idle", int_n, 0);
        cs_n = 1'b0; wr_n = 1'b0;
        tick(4);
        chk("R7 int released by WR", int_n, 1);
        wr_n = 1'b1; tick(1); cs_n = 1'b1;
        tick(40);
        chk("R7 int low after the WR-started conversion", int_n, 0);
        read_check("R7", expect_word(1, 5));
    endtask

    initial begin
        tick(4);
        test_reset();
        rst_n = 1'b1;
        tick(2);
        test_values();
        test_cal_hold();
        test_busy_ignore();
        test_cs_gate();
        test_int_by_wr();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule